// File: doc/BRIEF.md
# Preloaded Tagless Loop Cache

This block is a small instruction store placed beside a processor's fetch path. A profiling step, which is not part of this block, picks the hot loops of a fixed application. During system reset those loops are written into a tagless array. A small bank of loop descriptors is written at the same time. Each descriptor holds a first address, a last address and a base slot in the array. After the load phase ends, nothing inside the block changes except the record of which loop is currently running.

Each stored word carries one extra flag. The flag states whether a control-flow change taken at that instruction leaves the loop. A fetch is served from the array while it stays inside the running loop's address range. The main-memory fetch enable is dropped for every fetch served this way. A detection-mode parameter picks how a loop is entered:
- In start-address mode, every fetch address is compared with the loop start addresses, so serving begins on the first iteration.
- In branch-triggered mode, the comparison counts only when a taken short backwards branch has just redirected fetch to the start address, so serving begins on the second iteration.

All outputs are combinational on the current fetch inputs and the registered loop state.

Top module: `preload_loop_cache`

## Requirements
- R1: While rst_ni is low, hit_o is 0, instr_o is 0 and mem_en_o equals fetch_valid_i.
- R2: Array writes and descriptor writes take effect only while load_mode_i is 1. Writes issued while it is 0 leave contents and descriptors unchanged. While load_mode_i is 1, hit_o is 0 and no loop is running.
- R3: In start-address mode (DETECT=DET_START), a valid fetch whose address equals a written descriptor's start address hits in the same cycle. instr_o is then the word at that descriptor's base slot.
- R4: In branch-triggered mode (DETECT=DET_BRANCH), a start-address match hits only when sbb_taken_i is 1 in that cycle. With sbb_taken_i at 0 and no loop running, every fetch misses.
- R5: While a loop is running, a valid fetch whose address lies between its start and end addresses, both inclusive, hits. instr_o is the word at slot (base + address − start) mod DEPTH.
- R6: A valid fetch outside the running loop's range misses and stops the loop. Later fetches miss until a new detection occurs.
- R7: When a hit fetch has cof_i at 1 and the stored exit flag set, that fetch is still served, and the loop stops from the next cycle on. With the exit flag clear, the loop keeps running.
- R8: When several descriptors share a matching start address, the lowest-numbered one is used.
- R9: mem_en_o is fetch_valid_i and not hit_o. instr_o is 0 on a miss. With fetch_valid_i at 0, hit_o and mem_en_o are 0 and the loop state is held.
- R10: A descriptor never written since reset never matches, even at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_mode_i | input | 1 | Preload phase; writes accepted, no serving |
| arr_we_i | input | 1 | Array word write strobe |
| arr_idx_i | input | IDX_W | Array slot to write |
| arr_data_i | input | DATA_W | Instruction word to store |
| arr_exit_i | input | 1 | Exit flag stored with the word |
| reg_we_i | input | 1 | Descriptor write strobe |
| reg_sel_i | input | SEL_W | Descriptor number |
| reg_start_i | input | ADDR_W | Loop first word address |
| reg_end_i | input | ADDR_W | Loop last word address |
| reg_base_i | input | IDX_W | Array slot of the loop's first word |
| fetch_valid_i | input | 1 | Fetch request this cycle |
| fetch_addr_i | input | ADDR_W | Fetch word address |
| sbb_taken_i | input | 1 | This fetch is the target of a taken short backwards branch |
| cof_i | input | 1 | The fetched instruction takes a control-flow change |
| instr_o | output | DATA_W | Served instruction word, 0 on a miss |
| hit_o | output | 1 | Fetch served from the array |
| mem_en_o | output | 1 | Main-memory fetch enable |

## Verification
hit_o, instr_o and mem_en_o are due in the same cycle as the fetch inputs that produce them. A change in loop state shows in the fetch after the clock edge. This covers entry, exit by flag, exit by range and stall hold. Preload writes are visible to a fetch presented after the clock edge that captured them. The bench drives inputs on the falling edge and compares both mode instances against its model one nanosecond later. It advances the model only at the rising edge, so every check sees exactly one registered update since the last stimulus.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic {
    DET_BRANCH = 1'b0,
    DET_START  = 1'b1
  } det_e;
endpackage

// File: rtl/lc_loop_regs.sv
module lc_loop_regs #(
  parameter int NUM_LOOPS = 4,
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 5,
  localparam int SEL_W    = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  wsel_i,
  input  logic [ADDR_W-1:0] wstart_i,
  input  logic [ADDR_W-1:0] wend_i,
  input  logic [IDX_W-1:0]  wbase_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              match_o,
  output logic [SEL_W-1:0]  match_sel_o,
  input  logic [SEL_W-1:0]  a_sel_i,
  output logic              a_valid_o,
  output logic [ADDR_W-1:0] a_start_o,
  output logic [ADDR_W-1:0] a_end_o,
  input  logic [SEL_W-1:0]  b_sel_i,
  output logic [ADDR_W-1:0] b_start_o,
  output logic [IDX_W-1:0]  b_base_o
);
  logic [ADDR_W-1:0] start_q [NUM_LOOPS];
  logic [ADDR_W-1:0] end_q   [NUM_LOOPS];
  logic [IDX_W-1:0]  base_q  [NUM_LOOPS];
  logic [NUM_LOOPS-1:0] valid_q;
  logic [NUM_LOOPS-1:0] hit_vec;

  for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_lr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_q[k] <= '0;
        end_q[k]   <= '0;
        base_q[k]  <= '0;
        valid_q[k] <= 1'b0;
      end else if (we_i && (wsel_i == SEL_W'(k))) begin
        start_q[k] <= wstart_i;
        end_q[k]   <= wend_i;
        base_q[k]  <= wbase_i;
        valid_q[k] <= 1'b1;
      end
    end
    assign hit_vec[k] = valid_q[k] && (addr_i == start_q[k]);
  end

  // lowest index wins
  always_comb begin
    match_sel_o = '0;
    for (int k = NUM_LOOPS - 1; k >= 0; k--) begin
      if (hit_vec[k]) match_sel_o = SEL_W'(k);
    end
  end
  assign match_o = |hit_vec;

  assign a_valid_o = valid_q[a_sel_i];
  assign a_start_o = start_q[a_sel_i];
  assign a_end_o   = end_q[a_sel_i];
  assign b_start_o = start_q[b_sel_i];
  assign b_base_o  = base_q[b_sel_i];
endmodule

// File: rtl/lc_store.sv
module lc_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wexit_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rexit_o
);
  logic [DATA_W-1:0] mem_q  [DEPTH];
  logic [DEPTH-1:0]  exit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      exit_q <= '0;
    end else if (we_i) begin
      mem_q[widx_i]  <= wdata_i;
      exit_q[widx_i] <= wexit_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
  assign rexit_o = exit_q[ridx_i];
endmodule

// File: rtl/preload_loop_cache.sv
module preload_loop_cache
  import lc_pkg::*;
#(
  parameter int   ADDR_W    = 16,
  parameter int   DATA_W    = 32,
  parameter int   DEPTH     = 32,
  parameter int   NUM_LOOPS = 4,
  parameter det_e DETECT    = DET_START,
  localparam int  IDX_W     = $clog2(DEPTH),
  localparam int  SEL_W     = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_mode_i,
  input  logic              arr_we_i,
  input  logic [IDX_W-1:0]  arr_idx_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              arr_exit_i,
  input  logic              reg_we_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [ADDR_W-1:0] reg_start_i,
  input  logic [ADDR_W-1:0] reg_end_i,
  input  logic [IDX_W-1:0]  reg_base_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              sbb_taken_i,
  input  logic              cof_i,
  output logic [DATA_W-1:0] instr_o,
  output logic              hit_o,
  output logic              mem_en_o
);
  logic             act_q;
  logic [SEL_W-1:0] act_sel_q;
  logic             m_any;
  logic [SEL_W-1:0] m_sel, use_sel;
  logic             a_valid;
  logic [ADDR_W-1:0] a_start, a_end, u_start, offs;
  logic [IDX_W-1:0] u_base, idx;
  logic [DATA_W-1:0] rdata;
  logic             rexit;
  logic             in_range, detect, serve, hit, leave;

  lc_loop_regs #(
    .NUM_LOOPS(NUM_LOOPS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (load_mode_i && reg_we_i),
    .wsel_i      (reg_sel_i),
    .wstart_i    (reg_start_i),
    .wend_i      (reg_end_i),
    .wbase_i     (reg_base_i),
    .addr_i      (fetch_addr_i),
    .match_o     (m_any),
    .match_sel_o (m_sel),
    .a_sel_i     (act_sel_q),
    .a_valid_o   (a_valid),
    .a_start_o   (a_start),
    .a_end_o     (a_end),
    .b_sel_i     (use_sel),
    .b_start_o   (u_start),
    .b_base_o    (u_base)
  );

  lc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (load_mode_i && arr_we_i),
    .widx_i  (arr_idx_i),
    .wdata_i (arr_data_i),
    .wexit_i (arr_exit_i),
    .ridx_i  (idx),
    .rdata_o (rdata),
    .rexit_o (rexit)
  );

  assign in_range = act_q && a_valid &&
                    (fetch_addr_i >= a_start) && (fetch_addr_i <= a_end);

  if (DETECT == DET_START) begin : g_det_start
    assign detect = m_any;
  end else begin : g_det_branch
    assign detect = m_any && sbb_taken_i;
  end

  assign serve   = fetch_valid_i && !load_mode_i;
  assign use_sel = in_range ? act_sel_q : m_sel;
  assign hit     = serve && (in_range || detect);
  assign offs    = fetch_addr_i - u_start;
  assign idx     = u_base + offs[IDX_W-1:0];
  assign leave   = cof_i && rexit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      act_sel_q <= '0;
    end else if (load_mode_i) begin
      act_q     <= 1'b0;
    end else if (fetch_valid_i) begin
      act_q     <= hit && !leave;
      act_sel_q <= use_sel;
    end
  end

  assign hit_o    = hit;
  assign instr_o  = hit ? rdata : '0;
  assign mem_en_o = fetch_valid_i && !hit;
endmodule

// File: rtl/lc_chk.sv
module lc_chk
  import lc_pkg::*;
#(
  parameter det_e DETECT = DET_START
) (
  input logic clk_i,
  input logic rst_ni,
  input logic load_mode_i,
  input logic fetch_valid_i,
  input logic sbb_taken_i,
  input logic cof_i,
  input logic hit_o,
  input logic mem_en_o,
  input logic act_q,
  input logic rexit
);
  a_r9_mem_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !mem_en_o);
  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> (!hit_o && !mem_en_o));
  a_r2_load_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_mode_i |-> !hit_o);
  a_r2_load_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_mode_i |=> !act_q);
  a_r7_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && cof_i && rexit) |=> !act_q);
  a_r4_branch_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DETECT == DET_BRANCH && !act_q && !sbb_taken_i) |-> !hit_o);
endmodule

bind preload_loop_cache lc_chk #(.DETECT(DETECT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .load_mode_i   (load_mode_i),
  .fetch_valid_i (fetch_valid_i),
  .sbb_taken_i   (sbb_taken_i),
  .cof_i         (cof_i),
  .hit_o         (hit_o),
  .mem_en_o      (mem_en_o),
  .act_q         (act_q),
  .rexit         (rexit)
);

// File: tb/sim_preload_loop_cache.sv
`timescale 1ns/1ps
module sim_preload_loop_cache;
  import lc_pkg::*;
  localparam int ADDR_W = 16, DATA_W = 32, DEPTH = 32, NL = 4;
  localparam int IDX_W = $clog2(DEPTH), SEL_W = $clog2(NL);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_mode_i = 1'b0, arr_we_i = 1'b0, arr_exit_i = 1'b0, reg_we_i = 1'b0;
  logic [IDX_W-1:0] arr_idx_i = '0, reg_base_i = '0;
  logic [DATA_W-1:0] arr_data_i = '0;
  logic [SEL_W-1:0] reg_sel_i = '0;
  logic [ADDR_W-1:0] reg_start_i = '0, reg_end_i = '0, fetch_addr_i = '0;
  logic fetch_valid_i = 1'b0, sbb_taken_i = 1'b0, cof_i = 1'b0;
  logic [DATA_W-1:0] instr0, instr1;
  logic hit0, hit1, men0, men1;

  always #2 clk_i = ~clk_i;

  preload_loop_cache #(.DETECT(DET_START)) u0 (
    .clk_i, .rst_ni, .load_mode_i, .arr_we_i, .arr_idx_i, .arr_data_i, .arr_exit_i,
    .reg_we_i, .reg_sel_i, .reg_start_i, .reg_end_i, .reg_base_i,
    .fetch_valid_i, .fetch_addr_i, .sbb_taken_i, .cof_i,
    .instr_o(instr0), .hit_o(hit0), .mem_en_o(men0));
  preload_loop_cache #(.DETECT(DET_BRANCH)) u1 (
    .clk_i, .rst_ni, .load_mode_i, .arr_we_i, .arr_idx_i, .arr_data_i, .arr_exit_i,
    .reg_we_i, .reg_sel_i, .reg_start_i, .reg_end_i, .reg_base_i,
    .fetch_valid_i, .fetch_addr_i, .sbb_taken_i, .cof_i,
    .instr_o(instr1), .hit_o(hit1), .mem_en_o(men1));

  // reference model
  int unsigned m_data [DEPTH];
  bit m_exit [DEPTH];
  int m_start [NL], m_end [NL], m_base [NL];
  bit m_valid [NL];
  bit m_act [2];
  int m_sel [2];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = 0; m_exit[i] = 0; end
    for (int k = 0; k < NL; k++) begin
      m_start[k] = 0; m_end[k] = 0; m_base[k] = 0; m_valid[k] = 0;
    end
    for (int v = 0; v < 2; v++) begin m_act[v] = 0; m_sel[v] = 0; end
  endtask

  // v=0 start-address mode, v=1 branch mode
  task automatic model_eval(input int v, output bit h, output int s, output int idx);
    bit inr, found;
    int k0;
    int a;
    a = int'(fetch_addr_i);
    found = 0; k0 = 0;
    for (int k = NL - 1; k >= 0; k--)
      if (m_valid[k] && a == m_start[k]) begin found = 1; k0 = k; end
    inr = m_act[v] && m_valid[m_sel[v]] && a >= m_start[m_sel[v]] && a <= m_end[m_sel[v]];
    h = 0; s = k0;
    if (rst_ni && !load_mode_i && fetch_valid_i) begin
      if (inr) begin h = 1; s = m_sel[v]; end
      else if (found && (v == 0 || sbb_taken_i)) h = 1;
    end
    idx = (m_base[s] + a - m_start[s]) & (DEPTH - 1);
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    bit h [2];
    int s [2], ix [2];
    #1;
    for (int v = 0; v < 2; v++) model_eval(v, h[v], s[v], ix[v]);
    chk(tag, "u0 hit", int'(hit0), int'(h[0]));
    chk(tag, "u0 mem_en", int'(men0), int'(fetch_valid_i && !h[0]));
    chk(tag, "u0 instr", int'(instr0), h[0] ? int'(m_data[ix[0]]) : 0);
    chk(tag, "u1 hit", int'(hit1), int'(h[1]));
    chk(tag, "u1 mem_en", int'(men1), int'(fetch_valid_i && !h[1]));
    chk(tag, "u1 instr", int'(instr1), h[1] ? int'(m_data[ix[1]]) : 0);
    @(posedge clk_i);
    if (!rst_ni) model_reset();
    else begin
      for (int v = 0; v < 2; v++) begin
        if (load_mode_i) m_act[v] = 0;
        else if (fetch_valid_i) begin
          m_act[v] = h[v] && !(cof_i && m_exit[ix[v]]);
          m_sel[v] = s[v];
        end
      end
      if (load_mode_i && arr_we_i) begin
        m_data[arr_idx_i] = arr_data_i; m_exit[arr_idx_i] = arr_exit_i;
      end
      if (load_mode_i && reg_we_i) begin
        m_start[reg_sel_i] = int'(reg_start_i); m_end[reg_sel_i] = int'(reg_end_i);
        m_base[reg_sel_i] = int'(reg_base_i); m_valid[reg_sel_i] = 1;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic wr_arr(input int i, input int unsigned d, input bit e, input string tag);
    arr_we_i = 1; arr_idx_i = IDX_W'(i); arr_data_i = d; arr_exit_i = e;
    step(tag);
    arr_we_i = 0;
  endtask

  task automatic wr_reg(input int k, input int s, input int e, input int b, input string tag);
    reg_we_i = 1; reg_sel_i = SEL_W'(k); reg_start_i = ADDR_W'(s);
    reg_end_i = ADDR_W'(e); reg_base_i = IDX_W'(b);
    step(tag);
    reg_we_i = 0;
  endtask

  task automatic fetch(input int a, input bit sbb, input bit cof, input string tag);
    fetch_valid_i = 1; fetch_addr_i = ADDR_W'(a); sbb_taken_i = sbb; cof_i = cof;
    step(tag);
    sbb_taken_i = 0; cof_i = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk_i);
    fetch_valid_i = 1; fetch_addr_i = 16'h0100;
    step("R1"); step("R1");
    rst_ni = 1;
    // preload phase
    load_mode_i = 1;
    for (int i = 0; i < DEPTH; i++)
      wr_arr(i, 32'hA500_0000 + i, (i == 5) || (i == 10), "R2");
    wr_reg(0, 16'h0100, 16'h0107, 0, "R2");
    wr_reg(1, 16'h0200, 16'h0203, 8, "R2");
    wr_reg(2, 16'h0100, 16'h0101, 20, "R8");
    fetch(16'h0100, 1, 0, "R2");
    load_mode_i = 0;
    // writes outside load phase must be ignored
    wr_arr(0, 32'hDEAD_BEEF, 1, "R2");
    wr_reg(3, 16'h0300, 16'h0303, 28, "R2");
    fetch(16'h0300, 1, 0, "R2");
    fetch(16'h0000, 1, 0, "R10");
    // first pass of loop 0: start mode hits, branch mode misses
    fetch(16'h00FF, 0, 0, "R9");
    for (int a = 16'h0100; a <= 16'h0107; a++) fetch(a, 0, a == 16'h0107, "R3");
    // second pass entered by branch
    fetch(16'h0100, 1, 0, "R4");
    fetch(16'h0101, 0, 0, "R5");
    fetch_valid_i = 0; step("R9"); step("R9");
    fetch(16'h0102, 0, 0, "R9");
    fetch(16'h0103, 0, 1, "R7");
    fetch(16'h0104, 0, 0, "R7");
    fetch(16'h0105, 0, 1, "R7");
    fetch(16'h0103, 0, 0, "R7");
    fetch(16'h0180, 0, 0, "R6");
    // loop 1 with exit flag but no branch, then leave range
    fetch(16'h0200, 1, 0, "R8");
    fetch(16'h0201, 0, 0, "R5");
    fetch(16'h0202, 0, 0, "R7");
    fetch(16'h0203, 0, 0, "R5");
    fetch(16'h0204, 0, 0, "R6");
    fetch(16'h0201, 0, 0, "R6");
    fetch(16'h0200, 0, 0, "R4");
    fetch(16'h0202, 0, 1, "R7");
    fetch(16'h0203, 0, 0, "R7");
    // load phase stops a running loop
    fetch(16'h0100, 1, 0, "R2");
    load_mode_i = 1; fetch(16'h0101, 0, 0, "R2");
    load_mode_i = 0; fetch(16'h0101, 0, 0, "R2");
    fetch_valid_i = 0; step("R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule